// File: doc/BRIEF.md
# Four-Row Column Gatherer (Dual-Result Transpose Unit)

This block is a double-width execution unit that takes four 64-bit words in a single issue, treats each word as one row of a 4x4 matrix of 16-bit elements, and returns two 64-bit words that are columns of that matrix. It sits between the row pass and the column pass of a two-dimensional filter. Two issues, one with each setting of the half-select input, deliver all four columns, which is a complete transpose. The unit does no arithmetic: every output bit is a copy of one input bit.

The unit has one pipeline register. Results and their valid flag appear one clock after the issue. While no issue is presented, the result registers keep their last value.

Top module: `quad_row_transposer`

## Requirements
- R1: While rst_n is low, res_valid is 0 and both res_lo and res_hi are all zeros.
- R2: res_valid is 1 in the cycle after a cycle with issue_valid at 1, and 0 in the cycle after a cycle with issue_valid at 0. Both results update on that same edge.
- R3: With half_sel at 0, lane k of res_lo (bits 16k+15 down to 16k) equals element 0 (bits 15:0) of operand k, where operand 0 is opnd0 and lane 0 is the lowest lane.
- R4: With half_sel at 0, lane k of res_hi equals element 1 (bits 31:16) of operand k.
- R5: With half_sel at 1, lane k of res_lo equals element 2 (bits 47:32) of operand k, and lane k of res_hi equals element 3 (bits 63:48) of operand k.
- R6: In a cycle with issue_valid at 0, res_lo and res_hi keep their previous values, whatever the operand and half_sel inputs carry.
- R7: The function is a pure bit routing. A single set input bit shows up as exactly one set output bit if its element lies in the selected half, and as no set bit otherwise.
- R8: Transposing a matrix with two issues (half_sel 0, then 1), then feeding the four resulting columns back in as rows and transposing again, returns the original four operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| issue_valid | input | 1 | An operation is issued this cycle |
| half_sel | input | 1 | 0 selects columns 0 and 1, 1 selects columns 2 and 3 |
| opnd0 | input | 64 | Matrix row 0, four 16-bit elements |
| opnd1 | input | 64 | Matrix row 1 |
| opnd2 | input | 64 | Matrix row 2 |
| opnd3 | input | 64 | Matrix row 3 |
| res_valid | output | 1 | Both results are valid |
| res_lo | output | 64 | Lower selected column (column 0 or 2) |
| res_hi | output | 64 | Upper selected column (column 1 or 3) |

## Verification
Two functions can fall in the same cycle: a new issue is captured while the previous result is still on the outputs, and the half-select changes between back-to-back issues. The bench drives both halves of one matrix in consecutive cycles and checks that each result reflects only the half selected in its own issue cycle. It also runs idle cycles with changed operands to show that the held result stays unchanged. The double transpose then checks the whole routing, comparing the returned rows with the rows that went in.

// File: rtl/quad_row_transposer.sv
module quad_row_transposer #(
  parameter int ELEM_W = 16,
  localparam int LANES = 4,
  localparam int WORD_W = ELEM_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic              half_sel,
  input  logic [WORD_W-1:0] opnd0,
  input  logic [WORD_W-1:0] opnd1,
  input  logic [WORD_W-1:0] opnd2,
  input  logic [WORD_W-1:0] opnd3,
  output logic              res_valid,
  output logic [WORD_W-1:0] res_lo,
  output logic [WORD_W-1:0] res_hi
);

  logic [WORD_W-1:0] rows [LANES];
  logic [1:0]        pick_lo, pick_hi;
  logic [WORD_W-1:0] gath_lo, gath_hi;

  assign rows[0] = opnd0;
  assign rows[1] = opnd1;
  assign rows[2] = opnd2;
  assign rows[3] = opnd3;

  assign pick_lo = {half_sel, 1'b0};
  assign pick_hi = {half_sel, 1'b1};

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign gath_lo[k*ELEM_W +: ELEM_W] = rows[k][pick_lo*ELEM_W +: ELEM_W];
    assign gath_hi[k*ELEM_W +: ELEM_W] = rows[k][pick_hi*ELEM_W +: ELEM_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_lo    <= '0;
      res_hi    <= '0;
    end else begin
      res_valid <= issue_valid;
      if (issue_valid) begin
        res_lo <= gath_lo;
        res_hi <= gath_hi;
      end
    end
  end

endmodule

module quad_row_transposer_chk #(
  parameter int ELEM_W = 16,
  localparam int WORD_W = ELEM_W * 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              issue_valid,
  input logic              half_sel,
  input logic [WORD_W-1:0] opnd0,
  input logic [WORD_W-1:0] opnd1,
  input logic [WORD_W-1:0] opnd2,
  input logic [WORD_W-1:0] opnd3,
  input logic              res_valid,
  input logic [WORD_W-1:0] res_lo,
  input logic [WORD_W-1:0] res_hi
);

  assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> res_valid);

  assert_valid_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |=> !res_valid);

  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |=> ($stable(res_lo) && $stable(res_hi)));

  assert_low_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !half_sel) |=>
      (res_lo[ELEM_W-1:0] == $past(opnd0[ELEM_W-1:0]) &&
       res_lo[WORD_W-1 -: ELEM_W] == $past(opnd3[ELEM_W-1:0])));

  assert_low_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !half_sel) |=>
      (res_hi[2*ELEM_W-1 -: ELEM_W] == $past(opnd1[2*ELEM_W-1 -: ELEM_W])));

  assert_high_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && half_sel) |=>
      (res_hi[WORD_W-1 -: ELEM_W] == $past(opnd3[WORD_W-1 -: ELEM_W]) &&
       res_lo[ELEM_W-1:0] == $past(opnd0[3*ELEM_W-1 -: ELEM_W])));

  assert_bit_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> ($countones({res_lo, res_hi}) <=
      $countones({$past(opnd0), $past(opnd1), $past(opnd2), $past(opnd3)})));

endmodule

bind quad_row_transposer quad_row_transposer_chk #(.ELEM_W(ELEM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .half_sel(half_sel),
  .opnd0(opnd0), .opnd1(opnd1), .opnd2(opnd2), .opnd3(opnd3),
  .res_valid(res_valid), .res_lo(res_lo), .res_hi(res_hi)
);

// File: tb/quad_row_transposer_tb.sv
module quad_row_transposer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic        half_sel = 1'b0;
  logic [63:0] opnd0 = '0, opnd1 = '0, opnd2 = '0, opnd3 = '0;
  logic        res_valid;
  logic [63:0] res_lo, res_hi;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  quad_row_transposer u_dut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .half_sel(half_sel),
    .opnd0(opnd0), .opnd1(opnd1), .opnd2(opnd2), .opnd3(opnd3),
    .res_valid(res_valid), .res_lo(res_lo), .res_hi(res_hi)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] elem(input logic [63:0] w, input int e);
    return w[16*e +: 16];
  endfunction

  function automatic logic [63:0] column(input logic [63:0] a, b, c, d, input int e);
    return {elem(d, e), elem(c, e), elem(b, e), elem(a, e)};
  endfunction

  task automatic issue(input logic [63:0] a, b, c, d, input logic hi);
    @(negedge clk);
    opnd0 = a; opnd1 = b; opnd2 = c; opnd3 = d;
    half_sel = hi; issue_valid = 1'b1;
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    @(negedge clk);
    issue_valid = 1'b0;
    @(posedge clk);
    #2;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] m [4];
    logic [63:0] c [4];
    logic [63:0] held_lo, held_hi;

    repeat (3) @(posedge clk);
    #2;
    check("R1 res_valid", {63'd0, res_valid}, 64'd0);
    check("R1 res_lo", res_lo, 64'd0);
    check("R1 res_hi", res_hi, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3 R4 R5: sweep of distinct element patterns, halves back to back
    for (int s = 0; s < 48; s++) begin
      for (int k = 0; k < 4; k++)
        for (int e = 0; e < 4; e++)
          m[k][16*e +: 16] = 16'((s * 977 + k * 64 + e * 16 + 3) ^ (s << 9));
      issue(m[0], m[1], m[2], m[3], 1'b0);
      check("R2 valid after issue", {63'd0, res_valid}, 64'd1);
      check("R3 column 0", res_lo, column(m[0], m[1], m[2], m[3], 0));
      check("R4 column 1", res_hi, column(m[0], m[1], m[2], m[3], 1));
      issue(m[0], m[1], m[2], m[3], 1'b1);
      check("R5 column 2", res_lo, column(m[0], m[1], m[2], m[3], 2));
      check("R5 column 3", res_hi, column(m[0], m[1], m[2], m[3], 3));
    end

    // R6: idle cycles with changing inputs
    held_lo = res_lo;
    held_hi = res_hi;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      issue_valid = 1'b0;
      half_sel = ~half_sel;
      opnd0 = ~opnd0; opnd1 = opnd1 + 64'd7; opnd2 = {opnd2[31:0], opnd2[63:32]}; opnd3 = '1;
      @(posedge clk);
      #2;
      check("R2 valid drops when idle", {63'd0, res_valid}, 64'd0);
      check("R6 res_lo held", res_lo, held_lo);
      check("R6 res_hi held", res_hi, held_hi);
    end

    // R7: all ones and walking single bit
    issue('1, '1, '1, '1, 1'b0);
    check("R7 all ones lo", res_lo, '1);
    check("R7 all ones hi", res_hi, '1);
    for (int k = 0; k < 4; k++)
      for (int b = 0; b < 64; b++)
        for (int h = 0; h < 2; h++) begin
          logic [63:0] w [4];
          for (int j = 0; j < 4; j++) w[j] = '0;
          w[k][b] = 1'b1;
          issue(w[0], w[1], w[2], w[3], h[0]);
          check("R7 set bit count", 64'($countones({res_lo, res_hi})),
                64'(((b / 16) / 2) == h));
        end

    // R8: double transpose
    for (int s = 0; s < 8; s++) begin
      for (int k = 0; k < 4; k++)
        m[k] = {16'(s * 4099 + k), 16'(k * 311 ^ s), 16'(s + 17 * k), 16'(~(k + s * 5))};
      issue(m[0], m[1], m[2], m[3], 1'b0);
      c[0] = res_lo; c[1] = res_hi;
      issue(m[0], m[1], m[2], m[3], 1'b1);
      c[2] = res_lo; c[3] = res_hi;
      issue(c[0], c[1], c[2], c[3], 1'b0);
      check("R8 row 0 restored", res_lo, m[0]);
      check("R8 row 1 restored", res_hi, m[1]);
      issue(c[0], c[1], c[2], c[3], 1'b1);
      check("R8 row 2 restored", res_lo, m[2]);
      check("R8 row 3 restored", res_hi, m[3]);
    end
    idle();
    check("R2 valid low at end", {63'd0, res_valid}, 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule